// File: doc/BRIEF.md
# Timer Event Flag Unit

This block collects the events of a general-purpose 16-bit timer into one 16-bit sticky status word and raises one interrupt request. It watches the free-running counter value against four compare registers, a shared fifth channel that works either as a compare or as a capture input, three capture inputs with programmable edge selection, and an 8-bit pulse accumulator. Each event sets its own flag. Software clears flags by writing ones to them. The interrupt request is the registered OR of every flag whose enable bit is set.

The capture inputs and the accumulator input are asynchronous. They pass through a two-flop synchronizer before edge detection. The accumulator flag is driven by a small state machine with two states. `PA_WAIT` means the gate is inactive and `PA_OPEN` means a timed period is running. The transition `PA_WAIT -> PA_OPEN` is taken when the gate level becomes active. The transition `PA_OPEN -> PA_WAIT` is taken when the gate level becomes inactive, and in gated mode that transition marks the end of the period. In event-counting mode the flag follows the active edge of the input instead.

Top module: `tmr_evt_flags`

## Requirements
- R1: The status layout is fixed. Bit 15 is the shared channel flag. Bits 14:11 are the compare flags for channels 4..1 (compare 1 at bit 11). Bits 10:8 are the capture flags for channels 3..1 (capture 1 at bit 8). Bit 7 is counter overflow, bit 5 is accumulator overflow and bit 4 is the accumulator flag. Bits 6 and 3:0 read zero, even after a clear write of all ones.
- R2: After reset, `status` is 0 and `irq` is 0.
- R3: A compare flag is set at the clock edge where `tcnt` equals its `oc_cmp` entry and is visible at that edge.
- R4: With `ch5_capture`=0, bit 15 is set when `tcnt` equals `ch5_cmp`, and edges on `cap_pin[3]` are ignored. With `ch5_capture`=1, bit 15 is set by the selected edge on `cap_pin[3]`, and a counter match is ignored.
- R5: Each capture channel has a 2-bit edge select: 00 is off, 01 is rising, 10 is falling, 11 is both edges. A pin change sets the flag on the third rising clock edge after it.
- R6: Bit 7 is set only when `tcnt` goes from 16'hFFFF to 16'h0000 on consecutive clocks.
- R7: Bit 5 is set only when `pacc` goes from 8'hFF to 8'h00 on consecutive clocks.
- R8: In event-counting mode (`pa_gated`=0), bit 4 is set on the active edge of `pa_pin`. The active edge is rising if `pa_active_low`=0 and falling if it is 1. The opposite edge is ignored.
- R9: In gated mode (`pa_gated`=1), bit 4 is set when the gate level goes from active to inactive. It is not set when the gate opens.
- R10: A clock with `clr_stb`=1 clears every flag whose `clr_mask` bit is 1. Flags whose mask bit is 0 keep their value.
- R11: If a flag's set event and its clear fall in the same cycle, the flag stays set.
- R12: `irq` is 1 in the cycle after any flag with its `irq_en` bit set is 1. It drops one cycle after all enabled flags are cleared. Flags whose enable bit is 0 never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tcnt | input | 16 | Free-running counter value |
| oc_cmp | input | 4x16 | Compare values, entry 0 is compare 1 |
| ch5_cmp | input | 16 | Compare value of the shared channel |
| ch5_capture | input | 1 | Shared channel mode: 0 compare, 1 capture |
| cap_pin | input | 4 | Capture inputs; bit 3 is the shared channel pin |
| cap_edge | input | 4x2 | Edge select for each capture input |
| pacc | input | 8 | Pulse accumulator value |
| pa_pin | input | 1 | Accumulator input or gate |
| pa_gated | input | 1 | 0 event counting, 1 gated time |
| pa_active_low | input | 1 | Accumulator input polarity |
| irq_en | input | 16 | Interrupt enable, one per status bit |
| clr_stb | input | 1 | Clear write strobe |
| clr_mask | input | 16 | Ones select flags to clear |
| status | output | 16 | Sticky flag word |
| irq | output | 1 | Registered interrupt request |

## Verification
Flag setting and software clearing can land on the same cycle. The bench provokes this by holding `tcnt` on the compare 1 value while it strobes a clear of bit 11. It judges the result by reading bit 11 as still set, and then reading it as clear after the match is removed and the clear is repeated. A similar overlap exists between flag clearing and the registered interrupt. The bench checks that `irq` stays high for exactly one cycle after the enabled flag reads zero.

// File: rtl/tef_pkg.sv
package tef_pkg;
    localparam int FLAG_W   = 16;
    localparam int SH_BIT   = 15;
    localparam int OC_LO    = 11;
    localparam int IC_LO    = 8;
    localparam int TOF_BIT  = 7;
    localparam int PAOV_BIT = 5;
    localparam int PAF_BIT  = 4;
    localparam int N_OC     = 4;
    localparam int N_IC     = 3;
    localparam logic [FLAG_W-1:0] LIVE_MASK = 16'hFFB0;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic {
        PA_WAIT = 1'b0,
        PA_OPEN = 1'b1
    } pa_state_e;
endpackage

// File: rtl/tef_edge_det.sv
module tef_edge_det
    import tef_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       level,
    output logic       hit
);
    logic [SYNC:0] sh_q;
    logic          rise, fall;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC-1:0], pin};
    end

    assign level = sh_q[SYNC-1];
    assign rise  = sh_q[SYNC-1] & ~sh_q[SYNC];
    assign fall  = ~sh_q[SYNC-1] & sh_q[SYNC];

    always_comb begin
        unique case (edge_sel_e'(sel))
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // R5
    rise_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sh_q[SYNC]);
endmodule

// File: rtl/tef_pacc_fsm.sv
module tef_pacc_fsm
    import tef_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic evt_hit,
    input  logic gated,
    input  logic active_low,
    output logic pa_set
);
    pa_state_e state_q, state_d;
    logic      act;

    assign act = level ^ active_low;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PA_WAIT: if (act)  state_d = PA_OPEN;
            PA_OPEN: if (!act) state_d = PA_WAIT;
            default: state_d = PA_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PA_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        if (gated) pa_set = (state_q == PA_OPEN) && !act;
        else       pa_set = evt_hit;
    end

    // R9
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && pa_set) |=> (state_q == PA_WAIT));
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
    import tef_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PACC_W = 8,
    parameter int SYNC   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            tcnt,
    input  logic [N_OC-1:0][CNT_W-1:0]  oc_cmp,
    input  logic [CNT_W-1:0]            ch5_cmp,
    input  logic                        ch5_capture,
    input  logic [N_IC:0]               cap_pin,
    input  logic [N_IC:0][1:0]          cap_edge,
    input  logic [PACC_W-1:0]           pacc,
    input  logic                        pa_pin,
    input  logic                        pa_gated,
    input  logic                        pa_active_low,
    input  logic [FLAG_W-1:0]           irq_en,
    input  logic                        clr_stb,
    input  logic [FLAG_W-1:0]           clr_mask,
    output logic [FLAG_W-1:0]           status,
    output logic                        irq
);
    localparam int N_CAP = N_IC + 1;

    logic [CNT_W-1:0]  tcnt_prev;
    logic [PACC_W-1:0] pacc_prev;
    logic [N_OC-1:0]   oc_hit;
    logic [N_CAP-1:0]  cap_hit;
    logic [N_CAP-1:0]  cap_lvl;
    logic              pa_lvl, pa_evt, pa_set;
    logic              tof_evt, paov_evt, sh_evt;
    logic [FLAG_W-1:0] set_vec, flags_q, flags_d;
    logic              irq_q;

    generate
        for (genvar i = 0; i < N_OC; i++) begin : g_oc
            assign oc_hit[i] = (tcnt == oc_cmp[i]);
        end
        for (genvar c = 0; c < N_CAP; c++) begin : g_cap
            tef_edge_det #(.SYNC(SYNC)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (cap_pin[c]),
                .sel   (cap_edge[c]),
                .level (cap_lvl[c]),
                .hit   (cap_hit[c])
            );
        end
    endgenerate

    tef_edge_det #(.SYNC(SYNC)) u_pa_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pa_pin),
        .sel   (pa_active_low ? EDGE_FALL : EDGE_RISE),
        .level (pa_lvl),
        .hit   (pa_evt)
    );

    tef_pacc_fsm u_pa_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (pa_lvl),
        .evt_hit    (pa_evt),
        .gated      (pa_gated),
        .active_low (pa_active_low),
        .pa_set     (pa_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_prev <= '0;
            pacc_prev <= '0;
        end else begin
            tcnt_prev <= tcnt;
            pacc_prev <= pacc;
        end
    end

    assign tof_evt  = (tcnt_prev == {CNT_W{1'b1}}) && (tcnt == '0);
    assign paov_evt = (pacc_prev == {PACC_W{1'b1}}) && (pacc == '0);
    assign sh_evt   = ch5_capture ? cap_hit[N_IC] : (tcnt == ch5_cmp);

    always_comb begin
        set_vec = '0;
        set_vec[SH_BIT] = sh_evt;
        for (int i = 0; i < N_OC; i++) set_vec[OC_LO + i] = oc_hit[i];
        for (int i = 0; i < N_IC; i++) set_vec[IC_LO + i] = cap_hit[i];
        set_vec[TOF_BIT]  = tof_evt;
        set_vec[PAOV_BIT] = paov_evt;
        set_vec[PAF_BIT]  = pa_set;
    end

    assign flags_d = ((flags_q & ~(clr_stb ? clr_mask : '0)) | set_vec) & LIVE_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= |(flags_q & irq_en);
        end
    end

    assign status = flags_q;
    assign irq    = irq_q;

    // R3
    oc1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt == oc_cmp[0]) |=> status[OC_LO]);
    // R6
    tof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tof_evt |=> status[TOF_BIT]);
    // R10
    tof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && clr_mask[TOF_BIT] && !tof_evt) |=> !status[TOF_BIT]);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && clr_mask[OC_LO] && oc_hit[0]) |=> status[OC_LO]);
    // R12
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_en) == '0) |=> !irq);
    // R12
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & irq_en)) |=> irq);
endmodule

// File: tb/tmr_evt_flags_tb_top.sv
module tmr_evt_flags_tb_top;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [15:0]       tcnt;
    logic [3:0][15:0]  oc_cmp;
    logic [15:0]       ch5_cmp;
    logic              ch5_capture;
    logic [3:0]        cap_pin;
    logic [3:0][1:0]   cap_edge;
    logic [7:0]        pacc;
    logic              pa_pin, pa_gated, pa_active_low;
    logic [15:0]       irq_en;
    logic              clr_stb;
    logic [15:0]       clr_mask;
    logic [15:0]       status;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [15:0] IDLE = 16'h0005;

    always #5 clk = ~clk;

    tmr_evt_flags dut_i (
        .clk(clk), .rst_n(rst_n), .tcnt(tcnt), .oc_cmp(oc_cmp), .ch5_cmp(ch5_cmp),
        .ch5_capture(ch5_capture), .cap_pin(cap_pin), .cap_edge(cap_edge),
        .pacc(pacc), .pa_pin(pa_pin), .pa_gated(pa_gated),
        .pa_active_low(pa_active_low), .irq_en(irq_en), .clr_stb(clr_stb),
        .clr_mask(clr_mask), .status(status), .irq(irq)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_stb = 1'b1; clr_mask = 16'hFFFF;
        tick(1);
        clr_stb = 1'b0; clr_mask = 16'h0000;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; tcnt = IDLE; ch5_cmp = 16'h2000; ch5_capture = 1'b0;
        for (int i = 0; i < 4; i++) oc_cmp[i] = 16'h1000 + 16'(i);
        cap_pin = '0; cap_edge = '0; pacc = 8'h10; pa_pin = 1'b0;
        pa_gated = 1'b0; pa_active_low = 1'b0; irq_en = '0;
        clr_stb = 1'b0; clr_mask = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R2 status", status, 16'h0000);
        chk("R2 irq", {15'b0, irq}, 16'h0000);

        // R3 sweep of the four compare channels
        for (int i = 0; i < 4; i++) begin
            clear_all();
            tcnt = oc_cmp[i];
            tick(1);
            tcnt = IDLE;
            chk("R3 compare flag", status, 16'(1) << (11 + i));
        end

        // R4 shared channel in compare mode
        clear_all();
        tcnt = ch5_cmp; tick(1); tcnt = IDLE;
        chk("R4 compare mode match", status, 16'h8000);
        clear_all();
        cap_edge[3] = 2'b11; cap_pin[3] = 1'b1; tick(4);
        chk("R4 compare mode ignores pin", status, 16'h0000);
        ch5_capture = 1'b1; cap_edge[3] = 2'b10; tick(1);
        clear_all();
        tcnt = ch5_cmp; tick(1); tcnt = IDLE;
        chk("R4 capture mode ignores match", status, 16'h0000);
        cap_pin[3] = 1'b0; tick(4);
        chk("R4 capture mode edge", status, 16'h8000);
        ch5_capture = 1'b0; cap_edge[3] = 2'b00;

        // R5 sweep: channel x edge select x direction
        for (int c = 0; c < 3; c++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                for (int d = 0; d < 2; d++) begin
                    logic rise;
                    logic [15:0] exp;
                    cap_edge[c] = 2'(cfg);
                    clear_all();
                    cap_pin[c] = ~cap_pin[c];
                    rise = cap_pin[c];
                    tick(4);
                    exp = ((cfg == 1 && rise) || (cfg == 2 && !rise) || cfg == 3)
                          ? (16'(1) << (8 + c)) : 16'h0000;
                    chk("R5 capture edge select", status, exp);
                end
            end
            cap_edge[c] = 2'b00;
        end
        // R5 latency
        cap_edge[0] = 2'b01;
        clear_all();
        cap_pin[0] = 1'b1;
        tick(2);
        chk("R5 not before third edge", status, 16'h0000);
        tick(1);
        chk("R5 set at third edge", status, 16'h0100);
        cap_edge[0] = 2'b00;

        // R6 counter overflow
        clear_all();
        tcnt = 16'hFFFF; tick(1); tcnt = 16'h0000; tick(1); tcnt = IDLE;
        chk("R6 wrap sets", status, 16'h0080);
        clear_all();
        tcnt = 16'h0001; tick(1); tcnt = 16'h0000; tick(1);
        tcnt = 16'hFFFF; tick(1); tcnt = 16'hFFFE; tick(1); tcnt = IDLE;
        chk("R6 no wrap no flag", status, 16'h0000);

        // R7 accumulator overflow
        clear_all();
        pacc = 8'hFF; tick(1); pacc = 8'h00; tick(1); pacc = 8'h10;
        chk("R7 wrap sets", status, 16'h0020);
        clear_all();
        pacc = 8'h7F; tick(1); pacc = 8'h00; tick(1); pacc = 8'h10;
        chk("R7 no wrap no flag", status, 16'h0000);

        // R8 event counting
        clear_all();
        pa_pin = 1'b1; tick(4);
        chk("R8 rising active", status, 16'h0010);
        clear_all();
        pa_pin = 1'b0; tick(4);
        chk("R8 falling ignored", status, 16'h0000);
        pa_active_low = 1'b1; tick(1);
        clear_all();
        pa_pin = 1'b1; tick(4);
        chk("R8 low polarity rising ignored", status, 16'h0000);
        pa_pin = 1'b0; tick(4);
        chk("R8 low polarity falling active", status, 16'h0010);

        // R9 gated time
        pa_active_low = 1'b0; tick(2);
        clear_all();
        pa_gated = 1'b1; tick(1);
        pa_pin = 1'b1; tick(4);
        chk("R9 gate open no flag", status, 16'h0000);
        pa_pin = 1'b0; tick(4);
        chk("R9 gate close sets", status, 16'h0010);
        pa_gated = 1'b0;

        // R10 / R1 clearing
        clear_all();
        chk("R1 reserved bits after all-ones clear", status & 16'h004F, 16'h0000);
        tcnt = 16'hFFFF; tick(1); tcnt = 16'h0000; tick(1);
        tcnt = oc_cmp[0]; tick(1); tcnt = oc_cmp[3]; tick(1); tcnt = IDLE;
        chk("R1 bit positions", status, 16'h4880);
        clr_stb = 1'b1; clr_mask = 16'h0000; tick(1);
        chk("R10 zero mask no effect", status, 16'h4880);
        clr_mask = 16'h0800; tick(1); clr_stb = 1'b0; clr_mask = '0;
        chk("R10 selective clear", status, 16'h4080);

        // R11 set wins over clear
        clear_all();
        tcnt = oc_cmp[0]; tick(1);
        clr_stb = 1'b1; clr_mask = 16'h0800; tick(1);
        chk("R11 set wins", status, 16'h0800);
        tcnt = IDLE; tick(1);
        clr_stb = 1'b0; clr_mask = '0;
        chk("R11 clear after event gone", status, 16'h0000);

        // R12 interrupt request
        irq_en = 16'h0800;
        clear_all(); tick(1);
        tcnt = oc_cmp[1]; tick(1); tcnt = IDLE; tick(1);
        chk("R12 disabled flag no irq", {15'b0, irq}, 16'h0000);
        tcnt = oc_cmp[0]; tick(1); tcnt = IDLE;
        chk("R12 flags present", status, 16'h1800);
        chk("R12 irq registered lag", {15'b0, irq}, 16'h0000);
        tick(1);
        chk("R12 irq raised", {15'b0, irq}, 16'h0001);
        clr_stb = 1'b1; clr_mask = 16'h0800; tick(1);
        clr_stb = 1'b0; clr_mask = '0;
        chk("R12 flag cleared", status, 16'h1000);
        chk("R12 irq held one cycle", {15'b0, irq}, 16'h0001);
        tick(1);
        chk("R12 irq dropped", {15'b0, irq}, 16'h0000);

        summary();
    end
endmodule